// File: doc/BRIEF.md
# Quadrature-Clock Sampling Time Interpolator Channel

This block is a single time-to-digital channel. It timestamps each rising and each falling edge of a hit input against a free-running reference clock. The fine part of the time comes from the hit edge sampling four clock phases: phase 0, phase 90, and their inverted copies phase 180 and phase 270. These split each reference period into four bins. The coarse part comes from a pair of counters. One counts on the rising edge of phase 0. The other is a copy of the first, updated half a period later on the falling edge of phase 0.

The 4-bit sample code is decoded through a writable 16-entry correction table, so a code damaged by metastability still maps to one bin. The decoded bin then chooses which counter value to use. This means a hit close to a counter transition always reads a counter that was stable when the hit arrived. A leading-edge word and a trailing-edge word leave the block, each with its own one-cycle valid strobe in the phase-0 domain. The leading and trailing paths run independently of each other.

Top module: `tdc_channel`

## Requirements
- R1: While rstN is low at a phase0 rising edge, both valid outputs are low and the coarse counter is cleared. The first phase0 rising edge with rstN high sets the coarse count to 1, and each later rising edge adds one.
- R2: A rising edge on hitIn gives exactly one leadValid pulse, one phase0 cycle wide, with the timestamp in leadStamp.
- R3: A falling edge on hitIn gives exactly one trailValid pulse, one phase0 cycle wide, with its own timestamp in trailStamp. This path is independent of the leading path.
- R4: The fine field holds 0, 1, 2 or 3 when the edge lies in one of these windows after a phase0 rising edge: before the phase90 rise, before the phase0 fall, before the phase90 fall, or before the next phase0 rise.
- R5: The coarse field equals the coarse count in force when the edge arrived, in every bin. This holds in bins 0 and 3, which take their value from the half-cycle-delayed counter.
- R6: The coarse field is 15 bits wide and wraps from 32767 to 0.
- R7: A timestamp is 17 bits wide: the coarse count in bits 16:2 and the fine bin in bits 1:0.
- R8: The sample code is {phase0, phase90, phase180, phase270} with phase0 in bit 3. After reset the table maps the valid codes 4'b1001, 4'b1100, 4'b0110 and 4'b0011 to bins 0 to 3. Every other code maps to a bin set by bits 3:2 alone: 10 gives 0, 11 gives 1, 01 gives 2, 00 gives 3. For example, 4'b0100 maps to bin 2.
- R9: When cfgWrite is high at a phase0 rising edge, table entry cfgAddr takes the value cfgBin. Edges decoded after that use the new mapping.
- R10: A valid strobe rises on the third phase0 rising edge after the hit edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phase0 | input | 1 | Reference clock, 0 degrees; also clocks all logic in the block |
| phase90 | input | 1 | Reference clock delayed by a quarter period |
| phase180 | input | 1 | Inverted copy of phase0 |
| phase270 | input | 1 | Inverted copy of phase90 |
| rstN | input | 1 | Synchronous active-low reset, sampled by phase0 |
| hitIn | input | 1 | Hit signal to be timed |
| cfgWrite | input | 1 | Write strobe for the correction table |
| cfgAddr | input | 4 | Sample code whose table entry is written |
| cfgBin | input | 2 | Bin value written into the table |
| leadValid | output | 1 | One-cycle strobe for a new leading-edge timestamp |
| leadStamp | output | 17 | Leading-edge timestamp {coarse, fine} |
| trailValid | output | 1 | One-cycle strobe for a new trailing-edge timestamp |
| trailStamp | output | 17 | Trailing-edge timestamp {coarse, fine} |

## Verification
The hardest situation to reach is a non-ideal sample code. With clean clocks, the inverted phases always mirror phase 0 and phase 90, so only the four valid codes can ever appear. The bench therefore delays its phase180 copy by 1 ns and places a hit edge 0.5 ns after the phase0 fall. The edge then sees phase0 already low while phase180 is not yet high, which gives code 4'b0100. The bench checks the default decode for this code, rewrites that table entry, and repeats the same hit to see the new bin. Bins 0 and 3 are placed right next to the counter wrap, so the half-cycle counter path is checked while it carries across 32767.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  localparam int FINE_W = 2;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic capLead;
    logic capTrail;
  } tdcStrobe_t;

  // Bin from the phase0 and phase90 samples alone: a Gray decode that is
  // exact for valid codes and lands next to the true bin otherwise.
  function automatic logic [FINE_W-1:0] defaultBin(input logic [CODE_W-1:0] code);
    logic [FINE_W-1:0] bin;
    case (code[3:2])
      2'b10:   bin = 2'd0;
      2'b11:   bin = 2'd1;
      2'b01:   bin = 2'd2;
      default: bin = 2'd3;
    endcase
    return bin;
  endfunction

endpackage

// File: rtl/tdcEdgeCapture.sv
module tdcEdgeCapture #(
  parameter int COARSE_W = 15,
  parameter bit RISING   = 1'b1
) (
  input  logic                       hitIn,
  input  logic                       phase0,
  input  logic                       phase90,
  input  logic                       phase180,
  input  logic                       phase270,
  input  logic [COARSE_W-1:0]        cntA,
  input  logic [COARSE_W-1:0]        cntB,
  output logic [tdc_pkg::CODE_W-1:0] code,
  output logic [COARSE_W-1:0]        capA,
  output logic [COARSE_W-1:0]        capB
);

  // The hit edge itself is the clock here; the phases are the data.
  generate
    if (RISING) begin : gRise
      always_ff @(posedge hitIn) begin
        code <= {phase0, phase90, phase180, phase270};
        capA <= cntA;
        capB <= cntB;
      end
    end else begin : gFall
      always_ff @(negedge hitIn) begin
        code <= {phase0, phase90, phase180, phase270};
        capA <= cntA;
        capB <= cntB;
      end
    end
  endgenerate

endmodule

// File: rtl/tdcCtrl.sv
module tdcCtrl
  import tdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       phase0,
  input  logic       rstN,
  input  logic       hitIn,
  output tdcStrobe_t strobes
);

  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] hitHist;

  always_ff @(posedge phase0) begin
    if (!rstN) hitHist <= '0;
    else       hitHist <= {hitHist[HIST_W-2:0], hitIn};
  end

  always_comb begin
    strobes.capLead  =  hitHist[HIST_W-2] & ~hitHist[HIST_W-1];
    strobes.capTrail = ~hitHist[HIST_W-2] &  hitHist[HIST_W-1];
  end

endmodule

// File: rtl/tdcDatapath.sv
module tdcDatapath
  import tdc_pkg::*;
#(
  parameter int COARSE_W = 15,
  localparam int STAMP_W = COARSE_W + FINE_W,
  localparam int TABLE_DEPTH = 1 << CODE_W
) (
  input  logic               phase0,
  input  logic               phase90,
  input  logic               phase180,
  input  logic               phase270,
  input  logic               rstN,
  input  logic               hitIn,
  input  tdcStrobe_t         strobes,
  input  logic               cfgWrite,
  input  logic [CODE_W-1:0]  cfgAddr,
  input  logic [FINE_W-1:0]  cfgBin,
  output logic               leadValid,
  output logic [STAMP_W-1:0] leadStamp,
  output logic               trailValid,
  output logic [STAMP_W-1:0] trailStamp
);

  logic [COARSE_W-1:0] cntA;
  logic [COARSE_W-1:0] cntB;
  logic [FINE_W-1:0]   binMap [TABLE_DEPTH];
  logic [1:0]          capStrobe;

  assign capStrobe = {strobes.capTrail, strobes.capLead};

  // Main counter steps on the phase0 rise; the shadow copy follows it on the fall.
  always_ff @(posedge phase0) begin
    if (!rstN) cntA <= '0;
    else       cntA <= cntA + COARSE_W'(1);
  end

  always_ff @(negedge phase0) begin
    cntB <= cntA;
  end

  always_ff @(posedge phase0) begin
    if (!rstN) begin
      for (int i = 0; i < TABLE_DEPTH; i++) binMap[i] <= defaultBin(CODE_W'(i));
    end else if (cfgWrite) begin
      binMap[cfgAddr] <= cfgBin;
    end
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : gEdge
      logic [CODE_W-1:0]   code;
      logic [COARSE_W-1:0] capA;
      logic [COARSE_W-1:0] capB;
      logic [FINE_W-1:0]   fineBin;
      logic [COARSE_W-1:0] coarseSel;
      logic                validR;
      logic [STAMP_W-1:0]  stampR;

      tdcEdgeCapture #(
        .COARSE_W (COARSE_W),
        .RISING   (g == 0)
      ) uCapture (
        .hitIn    (hitIn),
        .phase0   (phase0),
        .phase90  (phase90),
        .phase180 (phase180),
        .phase270 (phase270),
        .cntA     (cntA),
        .cntB     (cntB),
        .code     (code),
        .capA     (capA),
        .capB     (capB)
      );

      // Bins 0 and 3 sit around the main counter's step, so read the shadow there.
      always_comb begin
        fineBin = binMap[code];
        if (fineBin == 2'd0)      coarseSel = capB + COARSE_W'(1);
        else if (fineBin == 2'd3) coarseSel = capB;
        else                      coarseSel = capA;
      end

      always_ff @(posedge phase0) begin
        if (!rstN) begin
          validR <= 1'b0;
          stampR <= '0;
        end else begin
          validR <= capStrobe[g];
          if (capStrobe[g]) stampR <= {coarseSel, fineBin};
        end
      end
    end
  endgenerate

  assign leadValid  = gEdge[0].validR;
  assign leadStamp  = gEdge[0].stampR;
  assign trailValid = gEdge[1].validR;
  assign trailStamp = gEdge[1].stampR;

endmodule

// File: rtl/tdc_channel.sv
module tdc_channel
  import tdc_pkg::*;
#(
  parameter int COARSE_W = 15,
  localparam int STAMP_W = COARSE_W + FINE_W
) (
  input  logic               phase0,
  input  logic               phase90,
  input  logic               phase180,
  input  logic               phase270,
  input  logic               rstN,
  input  logic               hitIn,
  input  logic               cfgWrite,
  input  logic [CODE_W-1:0]  cfgAddr,
  input  logic [FINE_W-1:0]  cfgBin,
  output logic               leadValid,
  output logic [STAMP_W-1:0] leadStamp,
  output logic               trailValid,
  output logic [STAMP_W-1:0] trailStamp
);

  tdcStrobe_t strobes;

  tdcCtrl #(.SYNC_STAGES(2)) uCtrl (
    .phase0  (phase0),
    .rstN    (rstN),
    .hitIn   (hitIn),
    .strobes (strobes)
  );

  tdcDatapath #(.COARSE_W(COARSE_W)) uPath (
    .phase0     (phase0),
    .phase90    (phase90),
    .phase180   (phase180),
    .phase270   (phase270),
    .rstN       (rstN),
    .hitIn      (hitIn),
    .strobes    (strobes),
    .cfgWrite   (cfgWrite),
    .cfgAddr    (cfgAddr),
    .cfgBin     (cfgBin),
    .leadValid  (leadValid),
    .leadStamp  (leadStamp),
    .trailValid (trailValid),
    .trailStamp (trailStamp)
  );

endmodule

// File: rtl/tdcChannelChecker.sv
module tdcChannelChecker
  import tdc_pkg::*;
(
  input logic       phase0,
  input logic       rstN,
  input tdcStrobe_t strobes,
  input logic       leadValid,
  input logic       trailValid
);

  AST_LEAD_ONE_CYCLE: assert property (@(posedge phase0) disable iff (!rstN)
    leadValid |=> !leadValid); // R2

  AST_TRAIL_ONE_CYCLE: assert property (@(posedge phase0) disable iff (!rstN)
    trailValid |=> !trailValid); // R3

  AST_LEAD_AFTER_STROBE: assert property (@(posedge phase0) disable iff (!rstN)
    leadValid |-> $past(strobes.capLead)); // R10

  AST_TRAIL_AFTER_STROBE: assert property (@(posedge phase0) disable iff (!rstN)
    trailValid |-> $past(strobes.capTrail)); // R10

  AST_STROBE_TO_VALID: assert property (@(posedge phase0) disable iff (!rstN)
    strobes.capLead |=> leadValid); // R2

endmodule

bind tdc_channel tdcChannelChecker uChecker (
  .phase0     (phase0),
  .rstN       (rstN),
  .strobes    (strobes),
  .leadValid  (leadValid),
  .trailValid (trailValid)
);

// File: tb/tb_tdc_channel.sv
`timescale 1ns/1ps
module tb_tdc_channel;

  logic        phase0 = 1'b0;
  logic        phase90 = 1'b0;
  logic        phase180 = 1'b1;
  logic        phase270 = 1'b1;
  logic        rstN = 1'b0;
  logic        hitIn = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [3:0]  cfgAddr = 4'd0;
  logic [1:0]  cfgBin = 2'd0;
  logic        leadValid, trailValid;
  logic [16:0] leadStamp, trailStamp;

  realtime skew180 = 0.0;
  int errors = 0;
  int checks = 0;

  // Bench's own count of phase0 rising edges since reset release (R1).
  logic [14:0] refCnt = '0;

  int cycleIdx = 0;
  int leadCount = 0, trailCount = 0;
  int leadAt = 0, trailAt = 0;
  logic [16:0] leadGot = '0, trailGot = '0;

  tdc_channel dut (
    .phase0(phase0), .phase90(phase90), .phase180(phase180), .phase270(phase270),
    .rstN(rstN), .hitIn(hitIn), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgBin(cfgBin),
    .leadValid(leadValid), .leadStamp(leadStamp),
    .trailValid(trailValid), .trailStamp(trailStamp)
  );

  // 125 MHz, phase90 a quarter period behind phase0.
  initial begin
    #1;
    forever begin
      phase0 = 1'b1;
      #2 phase90 = 1'b1;
      #2 phase0 = 1'b0;
      #2 phase90 = 1'b0;
      #2;
    end
  end

  always @(phase0) begin
    #(skew180);
    phase180 = ~phase0;
  end

  always @(phase90) phase270 = ~phase90;

  always @(posedge phase0) refCnt <= rstN ? refCnt + 15'd1 : 15'd0;

  always @(negedge phase0) begin
    cycleIdx = cycleIdx + 1;
    if (leadValid)  begin leadCount++;  leadAt = cycleIdx;  leadGot = leadStamp;  end
    if (trailValid) begin trailCount++; trailAt = cycleIdx; trailGot = trailStamp; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] binOf(input real off);
    if (off < 2.0) return 2'd0;
    if (off < 4.0) return 2'd1;
    if (off < 6.0) return 2'd2;
    return 2'd3;
  endfunction

  function automatic int latOf(input real off);
    return (off < 4.0) ? 4 : 3;
  endfunction

  task automatic clearMon();
    leadCount = 0;
    trailCount = 0;
  endtask

  // Drive one edge at an offset after a phase0 rise; return expected stamp and start index.
  task automatic driveEdge(input bit level, input real off,
                           output logic [16:0] exp, output int startIdx);
    @(posedge phase0);
    #(off);
    exp = {refCnt, binOf(off)};
    startIdx = cycleIdx;
    hitIn = level;
  endtask

  task automatic verifyLead(input string req, input logic [16:0] exp, input int startIdx, input int lat);
    check(leadCount == 1, "R2", {req, " lead pulse count"}, leadCount, 1);
    check(leadAt - startIdx == lat, "R10", {req, " lead latency"}, leadAt - startIdx, lat);
    check(leadGot == exp, req, "lead stamp", leadGot, exp);
  endtask

  task automatic verifyTrail(input string req, input logic [16:0] exp, input int startIdx, input int lat);
    check(trailCount == 1, "R3", {req, " trail pulse count"}, trailCount, 1);
    check(trailAt - startIdx == lat, "R10", {req, " trail latency"}, trailAt - startIdx, lat);
    check(trailGot == exp, req, "trail stamp", trailGot, exp);
  endtask

  task automatic testReset();
    repeat (3) @(posedge phase0);
    @(negedge phase0);
    check(leadValid == 1'b0, "R1", "leadValid in reset", leadValid, 0);
    check(trailValid == 1'b0, "R1", "trailValid in reset", trailValid, 0);
    check(leadStamp == '0, "R1", "leadStamp in reset", leadStamp, 0);
    rstN = 1'b1;
    repeat (2) @(posedge phase0);
  endtask

  // R4 R5 R7: a full pulse, leading edge at riseOff, trailing edge at fallOff.
  task automatic testPair(input real riseOff, input real fallOff, input string req);
    logic [16:0] expL, expT;
    int sL, sT;
    clearMon();
    driveEdge(1'b1, riseOff, expL, sL);
    repeat (6) @(posedge phase0);
    verifyLead(req, expL, sL, latOf(riseOff));
    check(trailCount == 0, "R3", {req, " no trail on rise"}, trailCount, 0);
    clearMon();
    driveEdge(1'b0, fallOff, expT, sT);
    repeat (6) @(posedge phase0);
    verifyTrail(req, expT, sT, latOf(fallOff));
    check(leadCount == 0, "R2", {req, " no lead on fall"}, leadCount, 0);
  endtask

  // R6: bin 3 just before the wrap, bin 0 just after it.
  task automatic testWrap();
    logic [16:0] expL, expT;
    int sL, sT;
    while (refCnt != 15'h7FFE) @(negedge phase0);
    clearMon();
    driveEdge(1'b1, 7.0, expL, sL);
    driveEdge(1'b0, 1.0, expT, sT);
    repeat (6) @(posedge phase0);
    check(expL == {15'h7FFF, 2'd3}, "R6", "bench wrap setup lead", expL, {15'h7FFF, 2'd3});
    check(expT == {15'h0000, 2'd0}, "R6", "bench wrap setup trail", expT, 0);
    verifyLead("R6", expL, sL, 3);
    verifyTrail("R6", expT, sT, 4);
  endtask

  task automatic writeTable(input logic [3:0] addr, input logic [1:0] bin);
    @(negedge phase0);
    cfgWrite = 1'b1;
    cfgAddr = addr;
    cfgBin = bin;
    @(negedge phase0);
    cfgWrite = 1'b0;
  endtask

  // R8 R9: delayed phase180 makes code 4'b0100 just after the phase0 fall.
  task automatic testCorrection();
    logic [16:0] expL, expT;
    int sL, sT;
    skew180 = 1.0;
    repeat (2) @(posedge phase0);
    clearMon();
    driveEdge(1'b1, 4.5, expL, sL);
    repeat (6) @(posedge phase0);
    verifyLead("R8", {expL[16:2], 2'd2}, sL, 3);
    clearMon();
    driveEdge(1'b0, 3.0, expT, sT);
    repeat (6) @(posedge phase0);
    verifyTrail("R4", expT, sT, 4);
    writeTable(4'b0100, 2'd1);
    clearMon();
    driveEdge(1'b1, 4.5, expL, sL);
    repeat (6) @(posedge phase0);
    verifyLead("R9", {expL[16:2], 2'd1}, sL, 3);
    clearMon();
    driveEdge(1'b0, 3.0, expT, sT);
    repeat (6) @(posedge phase0);
    verifyTrail("R9", expT, sT, 4);
    skew180 = 0.0;
    repeat (2) @(posedge phase0);
  endtask

  initial begin
    testReset();
    testPair(1.0, 3.0, "R4");
    testPair(3.0, 5.0, "R5");
    testPair(5.0, 7.0, "R7");
    testPair(7.0, 1.0, "R5");
    testPair(0.5, 6.5, "R4");
    testCorrection();
    testWrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule